// File: doc/BRIEF.md
# DRAM Access and Refresh Sequencer

This block decides whether the next DRAM cycle serves the host or a refresh. It then drives the row and column strobes, the grant and acknowledge handshake and the address-source select. An outside datapath uses that select to put a row, column or refresh address on the memory address lines. An outside counter keeps the refresh backlog, raises the pending-refresh flag and advances on the refresh-done pulse.

The block runs on a clock at twice the memory cycle rate, so each clock is a half-cycle "tick". Ticks alternate between rising-phase and falling-phase, and the first tick after reset is a rising-phase tick. A host request is examined only on rising-phase ticks and a refresh request only on falling-phase ticks. Neither is examined until the row strobe has been high for the selected precharge time. Three inputs set the timing: a precharge select, a row-hold select, and a page-mode input that keeps the row strobe low for as long as the host holds its request.

Top module: `dram_seq`

## Requirements
- R1: While reset is asserted and on the first tick after it, ras_n and cas_n are 1, grant, ack and rfsh_done are 0 and addr_sel is 0 (row). A precharge interval starts at reset, so the first RAS fall occurs no earlier than tick 8 after release.
- R2: The host request is sampled on rising-phase ticks and the refresh flag on falling-phase ticks, and only while ras_n has been high for the precharge time. The request seen first is served first. The other request is served after that cycle and its precharge if it is still asserted.
- R3: An access begins with grant rising and ras_n falling on the same tick, with addr_sel = 0 (row).
- R4: addr_sel switches to 1 (column) 1 tick after the RAS fall when row_hold_short = 1, and 2 ticks after it when row_hold_short = 0.
- R5: cas_n falls exactly 3 ticks after ras_n falls in an access.
- R6: When page_en = 0, ras_n rises 8 ticks after its fall. ack rises on that same tick if host_req is still high.
- R7: After ack, grant, ack, cas_n and addr_sel hold their values while host_req stays high. On the tick after host_req is seen low, grant and ack become 0, cas_n becomes 1 and addr_sel becomes 0.
- R8: When page_en = 1, ack still rises 8 ticks after the RAS fall, but ras_n stays low until host_req is seen low. ras_n and cas_n then rise on the same tick as grant and ack fall.
- R9: A refresh cycle puts addr_sel = 2 (refresh) for one tick with ras_n high, then holds ras_n low for 8 ticks with cas_n high throughout. rfsh_done pulses for one tick on the tick where ras_n rises, and addr_sel returns to 0 on that tick.
- R10: ras_n stays high for at least 8 ticks between cycles when pre_short = 0 and at least 6 ticks when pre_short = 1. When a request is already waiting, the next cycle follows within one or two extra ticks.
- R11: If host_req drops before ack, the access still keeps ras_n low for 8 ticks and gives no ack. grant falls and all strobes release on the tick where ras_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the memory cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, level |
| rfsh_pend | input | 1 | At least one refresh is owed |
| page_en | input | 1 | Keep RAS low while the request is held |
| pre_short | input | 1 | 1: 6-tick precharge, 0: 8-tick precharge |
| row_hold_short | input | 1 | 1: column after 1 tick, 0: after 2 ticks |
| grant | output | 1 | Host access cycle granted |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ack | output | 1 | Access data phase complete |
| addr_sel | output | 2 | Address source: 0 row, 1 column, 2 refresh |
| rfsh_done | output | 1 | One-tick pulse at the end of a refresh |

## Verification
An access is run with each row-hold setting, which separates the 1-tick column switch from the 2-tick one. Page-mode accesses are held well past 8 ticks to show that RAS does not fall back on the normal end. The host request is also withdrawn early, which separates the path that completes the access from the path that only releases it. Refresh bursts of two are run with each precharge setting, so that the gap between back-to-back cycles shows which hold-off was applied. Both requests are then raised on the same tick, once aligned to each phase, to show that the phase of the tick decides which one wins.

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter int RAS_TICKS = 8,
  parameter int CAS_TICK  = 3,
  parameter int PRE_LONG  = 8,
  parameter int PRE_SHORT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_req,
  input  logic       rfsh_pend,
  input  logic       page_en,
  input  logic       pre_short,
  input  logic       row_hold_short,
  output logic       grant,
  output logic       ras_n,
  output logic       cas_n,
  output logic       ack,
  output logic [1:0] addr_sel,
  output logic       rfsh_done
);
  localparam int MAXT = (RAS_TICKS > PRE_LONG) ? RAS_TICKS : PRE_LONG;
  localparam int CW   = $clog2(MAXT + 1) + 1;
  localparam logic [1:0] SEL_ROW = 2'd0, SEL_COL = 2'd1, SEL_REF = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_DONE, S_RSET, S_RREF} st_t;

  st_t           st;
  logic          ph;
  logic [CW-1:0] cnt, pre;

  wire [CW-1:0] nxt    = cnt + 1'b1;
  wire [CW-1:0] need   = pre_short ? CW'(PRE_SHORT - 1) : CW'(PRE_LONG - 1);
  wire [CW-1:0] col_at = row_hold_short ? CW'(1) : CW'(2);
  wire          ready  = ras_n && (pre >= need);
  wire          rel    = !host_req &&
                         ((st == S_DONE) || (st == S_ACC && cnt >= CW'(RAS_TICKS - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; cnt <= '0; pre <= '0;
      ras_n <= 1'b1; cas_n <= 1'b1; grant <= 1'b0; ack <= 1'b0;
      addr_sel <= SEL_ROW; rfsh_done <= 1'b0;
    end else begin
      ph        <= ~ph;
      rfsh_done <= 1'b0;
      if (!ras_n)        pre <= '0;
      else if (pre != '1) pre <= pre + 1'b1;
      case (st)
        S_IDLE: begin
          if (ready && !ph && host_req) begin
            st <= S_ACC; ras_n <= 1'b0; grant <= 1'b1; cnt <= '0;
          end else if (ready && ph && rfsh_pend) begin
            st <= S_RSET; addr_sel <= SEL_REF;
          end
        end
        S_ACC: begin
          if (cnt != CW'(RAS_TICKS)) begin
            cnt <= nxt;
            if (nxt >= col_at)          addr_sel <= SEL_COL;
            if (nxt >= CW'(CAS_TICK))   cas_n <= 1'b0;
            if (nxt == CW'(RAS_TICKS)) begin
              ack <= 1'b1;
              if (!page_en) begin
                ras_n <= 1'b1; st <= S_DONE;
              end
            end
          end
        end
        S_RSET: begin
          ras_n <= 1'b0; cnt <= '0; st <= S_RREF;
        end
        S_RREF: begin
          cnt <= nxt;
          if (nxt == CW'(RAS_TICKS)) begin
            ras_n <= 1'b1; rfsh_done <= 1'b1; addr_sel <= SEL_ROW; st <= S_IDLE;
          end
        end
        default: ;
      endcase
      if (rel) begin
        st <= S_IDLE; ras_n <= 1'b1; cas_n <= 1'b1; grant <= 1'b0; ack <= 1'b0;
        addr_sel <= SEL_ROW;
      end
    end
  end

  p_grant_with_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> (!ras_n && addr_sel == SEL_ROW));

  p_cas_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (!$past(ras_n) && !$past(ras_n, 3) && $past(ras_n, 4)));

  p_ack_under_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> grant);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !host_req) |=> (!grant && !ack && cas_n && ras_n));

  p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ras_n && host_req) |=> !ras_n);

  p_refresh_no_cas_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_sel == SEL_REF) |-> cas_n);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_done |=> !rfsh_done);

  // shortest hold-off (6 ticks at default parameters)
  p_min_precharge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(ras_n, 1) && $past(ras_n, 2) && $past(ras_n, 3) &&
                      $past(ras_n, 4) && $past(ras_n, 5) && $past(ras_n, 6)));
endmodule

// File: tb/dram_seq_tb_top.sv
module dram_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, rfsh_pend = 1'b0, page_en = 1'b0, pre_short = 1'b0, row_hold_short = 1'b1;
  logic grant, ras_n, cas_n, ack, rfsh_done;
  logic [1:0] addr_sel;

  always #5 clk = ~clk;

  dram_seq dut_i (.clk(clk), .rst_n(rst_n), .host_req(host_req), .rfsh_pend(rfsh_pend),
    .page_en(page_en), .pre_short(pre_short), .row_hold_short(row_hold_short),
    .grant(grant), .ras_n(ras_n), .cas_n(cas_n), .ack(ack), .addr_sel(addr_sel),
    .rfsh_done(rfsh_done));

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural reference
  int m_mode = 0, m_age = 0, m_hi = 1;
  bit m_ph = 0;
  logic e_ras_n = 1, e_cas_n = 1, e_gnt = 0, e_ack = 0, e_done = 0;
  logic [1:0] e_sel = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_age = 0; m_hi = 1; m_ph = 0;
      e_ras_n = 1; e_cas_n = 1; e_gnt = 0; e_ack = 0; e_done = 0; e_sel = 0;
    end else begin
      automatic int need = pre_short ? 6 : 8;
      automatic bit rdy = e_ras_n && (m_hi >= need);
      automatic logic n_ras = e_ras_n, n_cas = e_cas_n, n_gnt = e_gnt, n_ack = e_ack;
      automatic logic [1:0] n_sel = e_sel;
      automatic int n_mode = m_mode, n_age = m_age;
      automatic bit release_now = 0;
      e_done = 0;
      case (m_mode)
        0: if (rdy && !m_ph && host_req) begin n_mode = 1; n_ras = 0; n_gnt = 1; n_age = 0; end
           else if (rdy && m_ph && rfsh_pend) begin n_mode = 3; n_sel = 2; end
        1: begin
          if (m_age < 8) begin
            n_age = m_age + 1;
            if (n_age >= (row_hold_short ? 1 : 2)) n_sel = 1;
            if (n_age >= 3) n_cas = 0;
            if (n_age == 8) begin
              n_ack = 1;
              if (!page_en) begin n_ras = 1; n_mode = 2; end
            end
          end
          if (!host_req && m_age >= 7) release_now = 1;
        end
        2: if (!host_req) release_now = 1;
        3: begin n_ras = 0; n_age = 0; n_mode = 4; end
        4: begin
          n_age = m_age + 1;
          if (n_age == 8) begin n_ras = 1; e_done = 1; n_sel = 0; n_mode = 0; end
        end
        default: ;
      endcase
      if (release_now) begin
        n_mode = 0; n_ras = 1; n_cas = 1; n_gnt = 0; n_ack = 0; n_sel = 0;
      end
      m_hi = n_ras ? (e_ras_n ? m_hi + 1 : 1) : 0;
      if (m_hi > 100) m_hi = 100;
      m_ph = ~m_ph;
      e_ras_n = n_ras; e_cas_n = n_cas; e_gnt = n_gnt; e_ack = n_ack; e_sel = n_sel;
      m_mode = n_mode; m_age = n_age;
    end
  end

  // observation of the ports
  int tk = 0, t_fall = -1, t_rise = 0, t_gnt = -1, t_col = -1, t_cas = -1, t_ack = -1;
  int t_ref = -1, t_done = -1, gap = 0, n_ack = 0, n_done = 0, n_casf = 0;
  logic sel_at_fall = 0;
  logic p_ras = 1, p_cas = 1, p_gnt = 0, p_ack = 0;
  logic [1:0] p_sel = 0;
  int backlog = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at tick %0d", tag, act, exp, tk);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    tk++;
    chk(ras_n == e_ras_n, "R3 ras_n", ras_n, e_ras_n);
    chk(cas_n == e_cas_n, "R5 cas_n", cas_n, e_cas_n);
    chk(grant == e_gnt, "R7 grant", grant, e_gnt);
    chk(ack == e_ack, "R6 ack", ack, e_ack);
    chk(addr_sel == e_sel, "R4 addr_sel", addr_sel, e_sel);
    chk(rfsh_done == e_done, "R9 rfsh_done", rfsh_done, e_done);
    if (p_ras && !ras_n) begin gap = tk - t_rise; t_fall = tk; sel_at_fall = (addr_sel == 0); end
    if (!p_ras && ras_n) t_rise = tk;
    if (!p_gnt && grant) t_gnt = tk;
    if (p_sel != 1 && addr_sel == 1) t_col = tk;
    if (p_sel != 2 && addr_sel == 2) t_ref = tk;
    if (p_cas && !cas_n) begin t_cas = tk; n_casf++; end
    if (!p_ack && ack) begin t_ack = tk; n_ack++; end
    if (rfsh_done) begin t_done = tk; n_done++; if (backlog > 0) backlog--; end
    p_ras = ras_n; p_cas = cas_n; p_gnt = grant; p_ack = ack; p_sel = addr_sel;
    rfsh_pend = (backlog > 0);
  endtask

  task automatic wait_grant();
    for (int i = 0; i < 40 && !grant; i++) tick();
  endtask

  task automatic wait_ack();
    for (int i = 0; i < 40 && !ack; i++) tick();
  endtask

  task automatic access(input bit hrow, input bit hold_more);
    row_hold_short = hrow; host_req = 1;
    wait_grant();
    chk(t_gnt == t_fall, "R3 grant with RAS", t_gnt, t_fall);
    chk(sel_at_fall, "R3 row select at start", sel_at_fall, 1);
    repeat (12) tick();
    chk(t_col - t_fall == (hrow ? 1 : 2), "R4 column delay", t_col - t_fall, hrow ? 1 : 2);
    chk(t_cas - t_fall == 3, "R5 cas delay", t_cas - t_fall, 3);
    chk(t_rise - t_fall == 8, "R6 ras width", t_rise - t_fall, 8);
    chk(t_ack == t_rise, "R6 ack with RAS rise", t_ack, t_rise);
    if (hold_more) begin
      chk(ack && grant && !cas_n && addr_sel == 1, "R7 outputs held", {ack, grant, cas_n, addr_sel}, 5'b11001);
    end
    host_req = 0;
    tick();
    chk(!ack && !grant && cas_n && addr_sel == 0, "R7 release", {ack, grant, cas_n, addr_sel}, 5'b00100);
    repeat (12) tick();
  endtask

  // the first tick after a refresh start's select tick fixes the phase reference
  task automatic align(input bit want_rising);
    automatic bit rising = ((t_ref - 1 - tk) % 2) != 0;
    if (rising != want_rising) tick();
  endtask

  initial begin
    int a0, d0, c0;
    host_req = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk(ras_n && cas_n && !grant && !ack && !rfsh_done && addr_sel == 0, "R1 reset state",
        {ras_n, cas_n, grant, ack, rfsh_done, addr_sel}, 7'b1100000);
    // R1 precharge after reset, then a held normal access
    wait_grant();
    chk(t_fall >= 8, "R1 first RAS after precharge", t_fall, 8);
    repeat (12) tick();
    chk(ack && grant && !cas_n && addr_sel == 1, "R7 outputs held", {ack, grant, cas_n, addr_sel}, 5'b11001);
    host_req = 0; tick();
    chk(!ack && !grant && cas_n, "R7 release", {ack, grant, cas_n}, 3'b001);
    repeat (12) tick();

    access(1, 1);
    access(0, 1);

    // R8 page mode, then R10 gap to an immediate follow-up
    page_en = 1; host_req = 1;
    wait_grant();
    repeat (22) tick();
    chk(!ras_n && ack, "R8 RAS held in page mode", {ras_n, ack}, 2'b01);
    host_req = 0; tick();
    chk(ras_n && cas_n && !grant && !ack, "R8 page release", {ras_n, cas_n, grant, ack}, 4'b1100);
    host_req = 1;
    wait_grant();
    chk(gap >= 8 && gap <= 9, "R10 long precharge access gap", gap, 8);
    repeat (10) tick();
    pre_short = 1; host_req = 0; tick();
    host_req = 1;
    wait_grant();
    chk(gap >= 6 && gap <= 7, "R10 short precharge access gap", gap, 6);
    repeat (10) tick();
    host_req = 0; page_en = 0; pre_short = 0;
    repeat (12) tick();

    // R11 early withdrawal
    a0 = n_ack; host_req = 1;
    wait_grant();
    repeat (2) tick();
    host_req = 0;
    repeat (10) tick();
    chk(n_ack == a0, "R11 no ack", n_ack, a0);
    chk(t_rise - t_fall == 8, "R11 full RAS width", t_rise - t_fall, 8);
    chk(!grant && ras_n && cas_n, "R11 released", {grant, ras_n, cas_n}, 3'b011);

    // R9 and R10 refresh bursts
    d0 = n_done; c0 = n_casf; backlog = 2; rfsh_pend = 1;
    for (int i = 0; i < 80 && n_done < d0 + 2; i++) tick();
    chk(n_done == d0 + 2, "R9 two refreshes", n_done, d0 + 2);
    chk(t_fall - t_ref == 1, "R9 address before RAS", t_fall - t_ref, 1);
    chk(t_rise - t_fall == 8 && t_done == t_rise, "R9 refresh width and done", t_rise - t_fall, 8);
    chk(n_casf == c0, "R9 no CAS in refresh", n_casf, c0);
    chk(gap >= 8 && gap <= 10, "R10 long refresh gap", gap, 8);
    repeat (10) tick();
    pre_short = 1; d0 = n_done; backlog = 2; rfsh_pend = 1;
    for (int i = 0; i < 80 && n_done < d0 + 2; i++) tick();
    chk(gap >= 6 && gap <= 8, "R10 short refresh gap", gap, 6);
    pre_short = 0;
    repeat (12) tick();

    // R2 both requests raised together on a rising-phase tick: access first
    align(1);
    d0 = n_done; host_req = 1; backlog = 1; rfsh_pend = 1;
    tick();
    chk(grant && addr_sel == 0, "R2 access wins on rising tick", {grant, addr_sel}, 3'b100);
    wait_ack(); host_req = 0;
    for (int i = 0; i < 40 && n_done == d0; i++) tick();
    chk(n_done == d0 + 1, "R2 refresh served after access", n_done, d0 + 1);
    repeat (12) tick();

    // R2 both raised on a falling-phase tick: refresh first
    align(0);
    a0 = n_ack; host_req = 1; backlog = 1; rfsh_pend = 1;
    tick();
    chk(!grant && addr_sel == 2, "R2 refresh wins on falling tick", {grant, addr_sel}, 3'b010);
    wait_grant(); wait_ack();
    chk(n_ack == a0 + 1, "R2 access served after refresh", n_ack, a0 + 1);
    host_req = 0;
    repeat (12) tick();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule